// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the word address for each beat of a four-beat cache-line burst. A start address is captured when either of two active-low address strobes is taken. One strobe comes from the processor and the other from the controller. From then on, an active-low advance input steps the low two address bits through the burst while the upper bits stay fixed.

The beat order is set by a static strap, `mode_il`. When the strap is high, the beats follow the interleaved order, where the low bits equal the start bits XOR the beat count. When the strap is low, the beats follow the linear order, where the low bits count upward from the start bits modulo four.

Three chip enables gate every load. The processor strobe takes priority over the controller strobe. It is also disregarded completely while `en1_n` is high. The output address is registered. The block has a synchronous reset.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `word_addr` becomes all zeros after that edge. The start bits and the beat count are also cleared.
- R2: A strobe is "seen" when `proc_stb_n` is low with `en1_n` low, or when `ctrl_stb_n` is low. A seen strobe is taken when `en1_n`=0, `en2`=1 and `en3_n`=0 at the edge. After that edge, `word_addr` equals `addr_in`, and the beat count restarts at 0.
- R3: When both strobes are low in one cycle with all enables active, exactly one load of `addr_in` takes place. No advance is applied in that cycle, even if `adv_n` is low.
- R4: While `en1_n` is high, a low `proc_stb_n` is ignored. With `ctrl_stb_n` high and `adv_n` low, the burst advances one beat exactly as if no strobe were present.
- R5: When a seen strobe occurs with the enables not all active, the address neither loads nor advances. `word_addr` keeps its value.
- R6: With `mode_il`=1, each advance makes `word_addr[1:0]` equal to the start bits XOR the new beat count. From start 01 the order is 01,00,11,10.
- R7: With `mode_il`=0, each advance makes `word_addr[1:0]` equal to the start bits plus the new beat count, modulo 4. From start 10 the order is 10,11,00,01.
- R8: The beat count is two bits wide and wraps. Four advances after a load return the low bits to the start value.
- R9: With no strobe seen and `adv_n` high, `word_addr` holds, which suspends the burst.
- R10: An advance never changes `word_addr[AW-1:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | AW | Start address offered with a strobe |
| proc_stb_n | input | 1 | Processor address strobe, active low, has priority |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| en1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| mode_il | input | 1 | Static strap: 1 selects interleaved order, 0 selects linear order |
| word_addr | output | AW | Registered word address of the current beat |

## Verification
Loading and advancing can be requested in the same cycle: a strobe arrives while `adv_n` is low. The bench provokes this with both strobes low together with a low advance, and with a processor strobe held low while `en1_n` is high. In the first case the reference model expects a clean load and no step. In the second case it expects a single step. A deselected strobe combined with a low advance is also judged, and the expected result there is that the address is frozen. The bench runs every start value in both orders, wrapping past four beats. It compares a behavioural model against `word_addr` after every edge.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_in,
  input  logic          proc_stb_n,
  input  logic          ctrl_stb_n,
  input  logic          adv_n,
  input  logic          en1_n,
  input  logic          en2,
  input  logic          en3_n,
  input  logic          mode_il,
  output logic [AW-1:0] word_addr
);

  localparam int LOW = 2;

  logic [LOW-1:0] start_q;
  logic [LOW-1:0] beat_q;

  wire selected    = ~en1_n & en2 & ~en3_n;
  wire proc_seen   = ~proc_stb_n & ~en1_n;
  wire strobe_seen = proc_seen | ~ctrl_stb_n;
  wire do_load     = strobe_seen & selected;
  wire do_step     = ~strobe_seen & ~adv_n;

  wire [LOW-1:0] beat_nx = beat_q + LOW'(1);
  wire [LOW-1:0] low_nx  = mode_il ? (start_q ^ beat_nx) : (start_q + beat_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= '0;
      beat_q    <= '0;
      word_addr <= '0;
    end else if (do_load) begin
      start_q   <= addr_in[LOW-1:0];
      beat_q    <= '0;
      word_addr <= addr_in;
    end else if (do_step) begin
      beat_q             <= beat_nx;
      word_addr[LOW-1:0] <= low_nx;
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    do_load |=> word_addr == $past(addr_in)); // R2

  AST_DESELECT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (strobe_seen && !selected) |=> $stable(word_addr)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (proc_stb_n && ctrl_stb_n && adv_n) |=> $stable(word_addr)); // R9

  AST_UPPER_STEADY: assert property (@(posedge clk) disable iff (rst)
    do_step |=> word_addr[AW-1:LOW] == $past(word_addr[AW-1:LOW])); // R10

  AST_IL_FLIP: assert property (@(posedge clk) disable iff (rst)
    (do_step && mode_il) |=> word_addr[0] != $past(word_addr[0])); // R6

  AST_LIN_INC: assert property (@(posedge clk) disable iff (rst)
    (do_step && !mode_il) |=> word_addr[LOW-1:0] == LOW'($past(word_addr[LOW-1:0]) + LOW'(1))); // R7

endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_in;
  logic          proc_stb_n, ctrl_stb_n, adv_n, en1_n, en2, en3_n, mode_il;
  logic [AW-1:0] word_addr;

  int checks = 0;
  int errors = 0;

  int m_addr = 0;
  int m_start = 0;
  int m_beat = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
    .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .mode_il(mode_il),
    .word_addr(word_addr)
  );

  task automatic cyc(input logic r, input logic [AW-1:0] a, input logic ps, input logic cs,
                     input logic adv, input logic e1, input logic e2, input logic e3,
                     input string tag);
    bit seen, sel;
    int low;
    rst = r; addr_in = a; proc_stb_n = ps; ctrl_stb_n = cs; adv_n = adv;
    en1_n = e1; en2 = e2; en3_n = e3;
    seen = (!ps && !e1) || !cs;
    sel  = !e1 && e2 && !e3;
    if (r) begin
      m_addr = 0; m_start = 0; m_beat = 0;
    end else if (seen && sel) begin
      m_addr = int'(a); m_start = int'(a) % 4; m_beat = 0;
    end else if (!seen && !adv) begin
      m_beat = (m_beat + 1) % 4;
      low = mode_il ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
      m_addr = (m_addr / 4) * 4 + low;
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (int'(word_addr) != m_addr) begin
      errors++;
      $display("FAIL %s: word_addr=%h expected=%h", tag, word_addr, m_addr[AW-1:0]);
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mode_il = 1'b1;
    @(negedge clk);
    cyc(1, 16'hFFFF, 0, 0, 0, 0, 1, 0, "R1 reset");
    cyc(1, 16'h1234, 1, 1, 1, 0, 1, 0, "R1 reset");

    cyc(0, 16'h1235, 0, 1, 1, 0, 1, 0, "R2 proc load");
    for (int i = 0; i < 4; i++) cyc(0, 16'h0000, 1, 1, 0, 0, 1, 0, "R6 R8 R10 interleaved step");
    cyc(0, 16'h7777, 1, 1, 1, 0, 1, 0, "R9 hold");
    cyc(0, 16'h7777, 1, 1, 1, 1, 0, 1, "R9 hold deselected");

    cyc(0, 16'hABCE, 0, 0, 0, 0, 1, 0, "R3 both strobes");
    cyc(0, 16'h5555, 0, 1, 0, 1, 1, 0, "R4 proc ignored advance");
    cyc(0, 16'h5555, 0, 0, 0, 1, 1, 0, "R5 ctrl with en1 high");
    cyc(0, 16'h4444, 1, 0, 0, 0, 0, 0, "R5 ctrl en2 low");
    cyc(0, 16'h4444, 0, 1, 0, 0, 1, 1, "R5 proc en3 high");
    cyc(0, 16'h4444, 1, 1, 0, 0, 1, 0, "R6 step after freeze");

    mode_il = 1'b0;
    cyc(0, 16'h0F02, 1, 0, 0, 0, 1, 0, "R2 ctrl load linear");
    for (int i = 0; i < 5; i++) cyc(0, 16'h0000, 1, 1, 0, 0, 1, 0, "R7 R8 R10 linear step");

    for (int m = 0; m < 2; m++) begin
      mode_il = m[0];
      for (int s = 0; s < 4; s++) begin
        cyc(0, 16'(16'h9A00 + s), 0, 1, 0, 0, 1, 0, "R2 load start");
        for (int k = 0; k < 4; k++) begin
          cyc(0, 16'h0000, 1, 1, 0, 0, 1, 0, m ? "R6 R8 order" : "R7 R8 order");
          cyc(0, 16'h0000, 1, 1, 1, 0, 1, 0, "R9 suspend");
        end
      end
    end

    cyc(1, 16'h1111, 1, 1, 0, 0, 1, 0, "R1 reset again");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule